// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block is a compact I/O interrupt controller for seven interrupt lines. Software reaches its registers indirectly: it first loads an 8-bit index register, then reads or writes the 32-bit data window, which maps onto whichever register the index selects. Besides an identification word, an arbitration-ID word and a fixed version word, the register space holds one 64-bit redirection entry per input line. Each entry is split across two consecutive indexes.

Each redirection entry carries a destination byte, a mask bit, a trigger-mode bit (edge or level) and a destination-mode bit (physical or logical). When an unmasked input becomes active, the block queues an interrupt request. Requests leave one at a time on a valid/ready output carrying the formatted destination byte, the entry number and the destination mode. When several entries wait at once, the lowest entry number goes first. A level-triggered entry asks again only after its line has been seen low, or after it is unmasked while its line is still high.

Top module: `irq_redir_ctrl`

## Requirements
- R1: A write pulse on `idx_we` loads `idx_wdata` into the index register. `win_rdata` always shows the word that the current index selects, and a write pulse on `win_we` stores `win_wdata` into that word. Index 00h is the identification word: bits 31:24 can be read and written, and every other bit reads 0. It resets to 0.
- R2: Index 01h reads 0006_0011h at all times. Bits 23:16 hold 6, the highest entry number, and bits 7:0 hold version 11h. Writes to this index change nothing.
- R3: Index 02h is the arbitration-ID word. Bits 31:24 can be read and written, every other bit reads 0, and it resets to 0.
- R4: Entry n (n = 0..6) has its low word at index 10h+2n and its high word at index 11h+2n. In the low word, bit 16 is the mask (1 = masked), bit 15 is the trigger mode (1 = level, 0 = edge) and bit 11 is the destination mode (1 = logical, 0 = physical). In the high word, bits 31:24 are the destination byte. All other bits of both words read 0. After reset every low word reads 0001_0000h and every high word reads 0.
- R5: Indexes 03h to 0Fh and 1Eh to FFh read 0, and writes to them have no effect.
- R6: A masked entry never causes a request, whatever its input line does.
- R7: In edge mode, a rising edge on an unmasked line makes `req_valid` rise two clock edges after the line is sampled high. Each edge yields exactly one request. Clearing the mask while the line is high yields no request.
- R8: In level mode, a line that is high on an unmasked entry yields a request. After that request is accepted, the entry does not ask again until the line has been seen low. Clearing the mask while the line is high yields a request, and `req_valid` rises on the second clock edge after the window write.
- R9: `req_entry` carries the entry number and `req_logical` carries the destination mode. `req_dest` carries the full destination byte in logical mode. In physical mode it carries only the low four bits of that byte, with bits 7:4 forced to 0.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_entry`, `req_dest` and `req_logical` hold steady. When several entries are eligible, the lowest entry number is sent first. The next request appears one cycle after the previous one is accepted.
- R11: After reset `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 8 | New index value |
| win_we | input | 1 | Write the data window |
| win_wdata | input | 32 | Data written through the window |
| win_rdata | output | 32 | Word selected by the current index |
| irq_in | input | 7 | Interrupt input lines, active high |
| req_valid | output | 1 | Interrupt request message valid |
| req_ready | input | 1 | Receiver accepts the request |
| req_dest | output | 8 | Formatted destination byte |
| req_entry | output | 3 | Entry number of the request |
| req_logical | output | 1 | Destination mode of the request (1 = logical) |

## Verification
A register access is due at the first falling edge after the rising edge that stores the index or the window data, because `win_rdata` is a combinational mux over registers. An edge-mode line becomes a request only after two rising edges: one captures the pending flag and one loads the output register. The bench therefore checks that `req_valid` is still low after the first edge and high after the second. A level line, or an unmask of a level entry, needs only the output-register edge after the triggering state is stored. After a handshake, the next request is due one edge later. Since `req_ready` stays low except during single-cycle accepts, every request is held and is sampled at a falling edge at those exact counts.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       logical;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0, logical: 1'b0};

  localparam logic [7:0] IDX_ID       = 8'h00;
  localparam logic [7:0] IDX_VER      = 8'h01;
  localparam logic [7:0] IDX_ARB      = 8'h02;
  localparam logic [7:0] IDX_RTE_BASE = 8'h10;
  localparam logic [7:0] VER_NUM      = 8'h11;

  localparam int unsigned BIT_MASK    = 16;
  localparam int unsigned BIT_LEVEL   = 15;
  localparam int unsigned BIT_LOGICAL = 11;

  function automatic logic [31:0] rte_lo_word(rte_t e);
    return {15'd0, e.mask, e.level, 3'd0, e.logical, 11'd0};
  endfunction

  function automatic logic [31:0] rte_hi_word(rte_t e);
    return {e.dest, 24'd0};
  endfunction

  function automatic logic [7:0] fmt_dest(rte_t e);
    return e.logical ? e.dest : {4'h0, e.dest[3:0]};
  endfunction

  function automatic logic [31:0] ver_word(int unsigned n_ent);
    logic [7:0] top_ent;
    top_ent = 8'(n_ent - 1);
    return {8'd0, top_ent, 8'd0, VER_NUM};
  endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENT = 7,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned DW      = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_we,
  input  logic [IDX_W-1:0]          idx_wdata,
  input  logic                      win_we,
  input  logic [DW-1:0]             win_wdata,
  output logic [DW-1:0]             win_rdata,
  output logic [IDX_W-1:0]          cur_idx,
  output rte_t [NUM_ENT-1:0]        entries,
  output logic [NUM_ENT-1:0]        unmask_pulse
);

  localparam int unsigned RTE_BASE = 32'(IDX_RTE_BASE);
  localparam int unsigned RTE_LAST = RTE_BASE + 2 * NUM_ENT - 1;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       id_q;
  logic [7:0]       arb_q;
  logic [IDX_W-1:0] off;
  logic [IDX_W-2:0] ent_num;
  logic             in_rte;
  logic             is_hi;

  assign cur_idx = idx_q;
  assign off     = idx_q - IDX_W'(RTE_BASE);
  assign ent_num = off[IDX_W-1:1];
  assign is_hi   = off[0];
  assign in_rte  = (32'(idx_q) >= RTE_BASE) && (32'(idx_q) <= RTE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      id_q  <= '0;
      arb_q <= '0;
    end else begin
      if (idx_we) idx_q <= idx_wdata;
      if (win_we && idx_q == IDX_W'(IDX_ID))  id_q  <= win_wdata[31:24];
      if (win_we && idx_q == IDX_W'(IDX_ARB)) arb_q <= win_wdata[31:24];
    end
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic sel, wr_lo, wr_hi;
    assign sel   = win_we && in_rte && (ent_num == (IDX_W-1)'(i));
    assign wr_lo = sel && !is_hi;
    assign wr_hi = sel && is_hi;
    assign unmask_pulse[i] = wr_lo && entries[i].mask && !win_wdata[BIT_MASK];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries[i] <= RTE_RESET;
      end else begin
        if (wr_lo) begin
          entries[i].mask    <= win_wdata[BIT_MASK];
          entries[i].level   <= win_wdata[BIT_LEVEL];
          entries[i].logical <= win_wdata[BIT_LOGICAL];
        end
        if (wr_hi) entries[i].dest <= win_wdata[31:24];
      end
    end
  end

  always_comb begin
    win_rdata = '0;
    if (idx_q == IDX_W'(IDX_ID)) begin
      win_rdata = {id_q, 24'd0};
    end else if (idx_q == IDX_W'(IDX_VER)) begin
      win_rdata = ver_word(NUM_ENT);
    end else if (idx_q == IDX_W'(IDX_ARB)) begin
      win_rdata = {arb_q, 24'd0};
    end else if (in_rte) begin
      for (int j = 0; j < NUM_ENT; j++) begin
        if (ent_num == (IDX_W-1)'(j))
          win_rdata = is_hi ? rte_hi_word(entries[j]) : rte_lo_word(entries[j]);
      end
    end
  end

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter int unsigned NUM_ENT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] irq_in,
  input  logic [NUM_ENT-1:0] mask_vec,
  input  logic [NUM_ENT-1:0] level_vec,
  input  logic [NUM_ENT-1:0] unmask_pulse,
  input  logic [NUM_ENT-1:0] acc_vec,
  output logic [NUM_ENT-1:0] req_vec,
  output logic [NUM_ENT-1:0] pend_vec
);

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_line
    logic prev_q, pend_q, armed_q, rise;

    assign rise = irq_in[i] && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        pend_q  <= 1'b0;
        armed_q <= 1'b1;
      end else begin
        prev_q <= irq_in[i];
        if (rise && !mask_vec[i] && !level_vec[i]) pend_q <= 1'b1;
        else if (acc_vec[i])                       pend_q <= 1'b0;
        if (!irq_in[i])          armed_q <= 1'b1;
        else if (acc_vec[i])     armed_q <= 1'b0;
        else if (unmask_pulse[i]) armed_q <= 1'b1;
      end
    end

    assign pend_vec[i] = pend_q;
    assign req_vec[i]  = !mask_vec[i] &&
                         (level_vec[i] ? (irq_in[i] && armed_q) : pend_q);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENT = 7,
  parameter int unsigned ENT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] req_vec,
  input  rte_t [NUM_ENT-1:0] entries,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ENT_W-1:0]   req_entry,
  output logic [7:0]         req_dest,
  output logic               req_logical,
  output logic [NUM_ENT-1:0] acc_vec,
  output logic               arb_load,
  output logic [ENT_W-1:0]   load_idx
);

  logic any_req;

  always_comb begin
    any_req  = 1'b0;
    load_idx = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (req_vec[k]) begin
        any_req  = 1'b1;
        load_idx = ENT_W'(k);
      end
    end
  end

  assign arb_load = any_req && !req_valid;

  always_comb begin
    acc_vec = '0;
    if (req_valid && req_ready) acc_vec[req_entry] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid   <= 1'b0;
      req_entry   <= '0;
      req_dest    <= '0;
      req_logical <= 1'b0;
    end else if (req_valid) begin
      if (req_ready) req_valid <= 1'b0;
    end else if (arb_load) begin
      req_valid   <= 1'b1;
      req_entry   <= load_idx;
      req_dest    <= fmt_dest(entries[load_idx]);
      req_logical <= entries[load_idx].logical;
    end
  end

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENT = 7,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned DW      = 32,
  localparam int unsigned ENT_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic [IDX_W-1:0]   idx_wdata,
  input  logic               win_we,
  input  logic [DW-1:0]      win_wdata,
  output logic [DW-1:0]      win_rdata,
  input  logic [NUM_ENT-1:0] irq_in,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [7:0]         req_dest,
  output logic [ENT_W-1:0]   req_entry,
  output logic               req_logical
);

  rte_t [NUM_ENT-1:0] entries;
  logic [NUM_ENT-1:0] unmask_pulse;
  logic [NUM_ENT-1:0] mask_vec;
  logic [NUM_ENT-1:0] level_vec;
  logic [NUM_ENT-1:0] req_vec;
  logic [NUM_ENT-1:0] pend_vec;
  logic [NUM_ENT-1:0] acc_vec;
  logic [IDX_W-1:0]   cur_idx;
  logic               arb_load;
  logic [ENT_W-1:0]   load_idx;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_vec
    assign mask_vec[i]  = entries[i].mask;
    assign level_vec[i] = entries[i].level;
  end

  irq_regfile #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .DW(DW)) u_regs (
    .clk, .rst_n, .idx_we, .idx_wdata, .win_we, .win_wdata, .win_rdata,
    .cur_idx, .entries, .unmask_pulse
  );

  irq_trigger #(.NUM_ENT(NUM_ENT)) u_trig (
    .clk, .rst_n, .irq_in, .mask_vec, .level_vec, .unmask_pulse,
    .acc_vec, .req_vec, .pend_vec
  );

  irq_arbiter #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_arb (
    .clk, .rst_n, .req_vec, .entries, .req_ready, .req_valid, .req_entry,
    .req_dest, .req_logical, .acc_vec, .arb_load, .load_idx
  );

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int unsigned NUM_ENT = 7,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned ENT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IDX_W-1:0]   cur_idx,
  input logic [DW-1:0]      win_rdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic [7:0]         req_dest,
  input logic [ENT_W-1:0]   req_entry,
  input logic               req_logical,
  input logic [NUM_ENT-1:0] mask_vec,
  input logic [NUM_ENT-1:0] req_vec,
  input logic               arb_load,
  input logic [ENT_W-1:0]   load_idx
);

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx == IDX_W'(1)) |-> (win_rdata == 32'h0006_0011)); // R2

  AST_NO_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    arb_load |-> !mask_vec[load_idx]); // R6

  AST_PHYS_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical) |-> (req_dest[7:4] == 4'h0)); // R9

  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_entry) &&
                                   $stable(req_dest) && $stable(req_logical))); // R10

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    arb_load |=> (req_valid && $countones(req_vec & $past(req_vec) &
                  ((NUM_ENT'(1) << req_entry) - NUM_ENT'(1))) == 0)); // R10

endmodule

bind irq_redir_ctrl irq_redir_chk #(
  .NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .DW(DW), .ENT_W(ENT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .win_rdata(win_rdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest),
  .req_entry(req_entry), .req_logical(req_logical), .mask_vec(mask_vec),
  .req_vec(req_vec), .arb_load(arb_load), .load_idx(load_idx)
);

// File: tb/test_irq_redir_ctrl.sv
module test_irq_redir_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic        win_we = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;
  logic [6:0]  irq_in = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [7:0]  req_dest;
  logic [2:0]  req_entry;
  logic        req_logical;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_redir_ctrl i_irq_redir_ctrl (
    .clk, .rst_n, .idx_we, .idx_wdata, .win_we, .win_wdata, .win_rdata,
    .irq_in, .req_valid, .req_ready, .req_dest, .req_entry, .req_logical
  );

  // {index, write, write data, expected read}
  localparam int NV = 14;
  localparam logic [72:0] REG_VEC [NV] = '{
    {8'h00, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R1
    {8'h01, 1'b0, 32'h0000_0000, 32'h0006_0011},  // R2
    {8'h00, 1'b1, 32'hFFFF_FFFF, 32'hFF00_0000},  // R1
    {8'h02, 1'b1, 32'h1234_5678, 32'h1200_0000},  // R3
    {8'h01, 1'b1, 32'hFFFF_FFFF, 32'h0006_0011},  // R2
    {8'h10, 1'b0, 32'h0000_0000, 32'h0001_0000},  // R4
    {8'h1D, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R4
    {8'h12, 1'b1, 32'hFFFF_FFFF, 32'h0001_8800},  // R4
    {8'h13, 1'b1, 32'hFFFF_FFFF, 32'hFF00_0000},  // R4
    {8'h12, 1'b1, 32'h0001_0000, 32'h0001_0000},  // R4
    {8'h13, 1'b1, 32'h0000_0000, 32'h0000_0000},  // R4
    {8'h1E, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {8'h07, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {8'hFF, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    @(negedge clk); idx_we = 1'b1; idx_wdata = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic win_wr(input logic [31:0] d);
    win_we = 1'b1; win_wdata = d;
    @(negedge clk); win_we = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [31:0] d);
    set_idx(i); win_wr(d);
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic chk_req(input string req, input logic [2:0] ent, input logic [7:0] dst,
                         input logic lg);
    chk(req, {29'd0, req_valid, lg ^ req_logical, 1'b0}, 32'h4);
    chk(req, {16'd0, 5'd0, req_entry, req_dest}, {16'd0, 5'd0, ent, dst});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset valid", {31'd0, req_valid}, 32'd0);

    // register table
    for (int v = 0; v < NV; v++) begin
      set_idx(REG_VEC[v][72:65]);
      if (REG_VEC[v][64]) win_wr(REG_VEC[v][63:32]);
      chk($sformatf("R1-table idx %h", REG_VEC[v][72:65]), win_rdata, REG_VEC[v][31:0]);
    end

    // R6: masked entry 0 ignores toggling input
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); irq_in[0] = ~irq_in[0];
    end
    repeat (3) @(negedge clk);
    chk("R6 masked no request", {31'd0, req_valid}, 32'd0);

    // R7 + R9: edge physical entry 2, exact latency
    reg_wr(8'h15, 32'h3500_0000);
    reg_wr(8'h14, 32'h0000_0000);
    irq_in[2] = 1'b1;
    @(negedge clk);
    chk("R7 edge not yet after 1 edge", {31'd0, req_valid}, 32'd0);
    @(negedge clk);
    chk_req("R7 R9 edge physical", 3'd2, 8'h05, 1'b0);
    repeat (3) @(negedge clk);
    chk_req("R10 held while not ready", 3'd2, 8'h05, 1'b0);
    accept();
    repeat (4) @(negedge clk);
    chk("R7 one request per edge", {31'd0, req_valid}, 32'd0);

    // R9: logical entry 3
    reg_wr(8'h17, 32'hA500_0000);
    reg_wr(8'h16, 32'h0000_0800);
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    chk_req("R9 logical dest", 3'd3, 8'hA5, 1'b1);
    accept();

    // R7: unmask edge entry 4 while line high -> nothing
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (2) @(negedge clk);
    reg_wr(8'h18, 32'h0000_0000);
    repeat (4) @(negedge clk);
    chk("R7 unmask edge no request", {31'd0, req_valid}, 32'd0);

    // R8: level entry 5, unmask while asserted
    reg_wr(8'h1B, 32'h0900_0000);
    reg_wr(8'h1A, 32'h0001_8000);
    @(negedge clk); irq_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 masked level no request", {31'd0, req_valid}, 32'd0);
    reg_wr(8'h1A, 32'h0000_8000);
    chk("R8 unmask level not yet", {31'd0, req_valid}, 32'd0);
    @(negedge clk);
    chk_req("R8 unmask level request", 3'd5, 8'h09, 1'b0);
    accept();
    repeat (4) @(negedge clk);
    chk("R8 no repeat while high", {31'd0, req_valid}, 32'd0);
    reg_wr(8'h1A, 32'h0001_8000);
    reg_wr(8'h1A, 32'h0000_8000);
    @(negedge clk);
    chk_req("R8 re-unmask level request", 3'd5, 8'h09, 1'b0);
    accept();
    irq_in[5] = 1'b0;
    @(negedge clk); irq_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk_req("R8 level after deassert", 3'd5, 8'h09, 1'b0);
    accept();
    irq_in[5] = 1'b0;

    // R10: entries 1 and 6 together, lowest first
    reg_wr(8'h13, 32'h0100_0000);
    reg_wr(8'h12, 32'h0000_0000);
    reg_wr(8'h1D, 32'h0600_0000);
    reg_wr(8'h1C, 32'h0000_0000);
    @(negedge clk); irq_in[1] = 1'b1; irq_in[6] = 1'b1;
    repeat (2) @(negedge clk);
    chk_req("R10 lowest first", 3'd1, 8'h01, 1'b0);
    accept();
    chk("R10 gap after accept", {31'd0, req_valid}, 32'd0);
    @(negedge clk);
    chk_req("R10 second request", 3'd6, 8'h06, 1'b0);
    accept();
    repeat (3) @(negedge clk);
    chk("R10 queue drained", {31'd0, req_valid}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule